// File: doc/BRIEF.md
# Flash Command Mode Controller

This block is the command front end of a parallel NOR-style flash device. The host writes command bytes on a 16-bit data bus. The block decodes the low byte of each write and keeps track of what a read returns: array data, status, the device identifier or the query table. It holds an 8-bit status byte. The progress bits in that byte follow a small program/erase engine. The error bits in it stay set until a dedicated clear command or a reset.

A stub engine drives the operation interface with single-cycle pulses: start (program or erase), done (with a fail flag), suspend and resume. The read mode moves to status read by itself when an operation starts or resumes. A one-cycle valid flag follows each read strobe. The flag is low when array data is requested while an operation is running. An unknown command code sets both sequence-error bits. Those bits then hide any erase failure reported later.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (readMode = 0), statusByte = 0x80 and readValid = 0.
- R2: A write of 0xFF selects readMode 0 (array), 0x70 selects 1 (status), 0x90 selects 2 (identifier) and 0x98 selects 3 (query), one cycle after the write strobe.
- R3: Only wrData[7:0] is decoded; the upper byte has no effect on the command.
- R4: A write of 0x50 clears status bits 5, 4 and 3 and selects readMode 1, at any level of progEnable.
- R5: Error bits 5, 4 and 3 stay set through reads, mode changes and operations until a clear (0x50) or reset.
- R6: An opStart while idle with progEnable = 1 starts the operation: status bit 7 (ready) drops to 0 and readMode becomes 1 on the next cycle.
- R7: An opStart while idle with progEnable = 0 starts nothing, sets status bit 3 and selects readMode 1.
- R8: A write of any code other than 0xFF, 0x70, 0x90, 0x98 or 0x50 sets status bits 5 and 4 and leaves readMode unchanged.
- R9: suspendReq during a running operation sets bit 7 and sets bit 6 (erase) or bit 2 (program). resumeReq while suspended clears those bits, drops bit 7 and forces readMode 1, even if array was selected during the suspend.
- R10: readValid is high in the cycle after a read strobe. It is low when the read is in array mode while an operation runs unsuspended.
- R11: opDone with opFail sets status bit 5 after an erase and bit 4 after a program. When bits 5 and 4 are already set by a sequence error, a failing erase leaves the status byte unchanged.
- R12: opDone without opFail on a running operation returns bit 7 to 1 and leaves the error bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | Command write strobe |
| wrData | input | 16 | Written data word; low byte is the command |
| rdStrobe | input | 1 | Read strobe |
| progEnable | input | 1 | Programming-enable level |
| opStart | input | 1 | Engine start pulse |
| opIsErase | input | 1 | Qualifies opStart: 1 erase, 0 program |
| opDone | input | 1 | Engine completion pulse |
| opFail | input | 1 | Qualifies opDone: operation failed |
| suspendReq | input | 1 | Suspend pulse |
| resumeReq | input | 1 | Resume pulse |
| readMode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| readValid | output | 1 | Registered validity of the last read strobe |
| statusByte | output | 8 | 7 ready, 6 erase suspended, 5 erase/seq error, 4 program/seq error, 3 enable error, 2 program suspended |

## Verification
The operation state is visible in the ready and suspend bits of statusByte, so a wrong state shows on the cycle after the pulse that should have moved it. A lost or wrongly cleared error bit stays visible at the port until the next clear. The checks read the status byte after every step of each scenario. A wrong read mode shows on readMode one cycle after a write, start or resume. It also shows as a wrong readValid one cycle after the next read strobe.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } readMode_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_SUSP = 2'd2
  } opState_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_CLEAR  = 8'h50;

  localparam int BIT_READY   = 7;
  localparam int BIT_ERSSUSP = 6;
  localparam int BIT_ERSERR  = 5;
  localparam int BIT_PGMERR  = 4;
  localparam int BIT_ENERR   = 3;
  localparam int BIT_PGMSUSP = 2;

  typedef struct packed {
    logic clrErr;
    logic setSeq;
    logic setEnable;
    logic setPgmFail;
    logic setErsFail;
  } errStrobe_t;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             progEnable,
  input  logic             opStart,
  input  logic             opIsErase,
  input  logic             opDone,
  input  logic             opFail,
  input  logic             suspendReq,
  input  logic             resumeReq,
  output readMode_e        modeQ,
  output opState_e         stateQ,
  output logic             eraseQ,
  output errStrobe_t       errStb
);

  readMode_e modeD;
  opState_e  stateD;
  logic      eraseD;

  always_comb begin
    modeD  = modeQ;
    stateD = stateQ;
    eraseD = eraseQ;
    errStb = '0;

    if (wrStrobe) begin
      unique case (cmdByte)
        CMD_ARRAY:  modeD = MODE_ARRAY;
        CMD_STATUS: modeD = MODE_STATUS;
        CMD_IDENT:  modeD = MODE_IDENT;
        CMD_QUERY:  modeD = MODE_QUERY;
        CMD_CLEAR: begin
          errStb.clrErr = 1'b1;
          modeD         = MODE_STATUS;
        end
        default:    errStb.setSeq = 1'b1;
      endcase
    end

    unique case (stateQ)
      OP_IDLE: begin
        if (opStart) begin
          modeD = MODE_STATUS;
          if (progEnable) begin
            stateD = OP_RUN;
            eraseD = opIsErase;
          end else begin
            errStb.setEnable = 1'b1;
          end
        end
      end
      OP_RUN: begin
        if (suspendReq) begin
          stateD = OP_SUSP;
        end else if (opDone) begin
          stateD = OP_IDLE;
          if (opFail) begin
            if (eraseQ) errStb.setErsFail = 1'b1;
            else        errStb.setPgmFail = 1'b1;
          end
        end
      end
      OP_SUSP: begin
        if (resumeReq) begin
          stateD = OP_RUN;
          modeD  = MODE_STATUS;
        end
      end
      default: stateD = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_ARRAY;
      stateQ <= OP_IDLE;
      eraseQ <= 1'b0;
    end else begin
      modeQ  <= modeD;
      stateQ <= stateD;
      eraseQ <= eraseD;
    end
  end

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_cmd_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  errStrobe_t          errStb,
  input  opState_e            opState,
  input  logic                opErase,
  input  readMode_e           mode,
  input  logic                rdStrobe,
  output logic                readValid,
  output logic [STATUS_W-1:0] statusByte
);

  logic ersErrQ, pgmErrQ, enErrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ersErrQ   <= 1'b0;
      pgmErrQ   <= 1'b0;
      enErrQ    <= 1'b0;
      readValid <= 1'b0;
    end else begin
      ersErrQ <= (ersErrQ & ~errStb.clrErr) | errStb.setSeq | errStb.setErsFail;
      pgmErrQ <= (pgmErrQ & ~errStb.clrErr) | errStb.setSeq | errStb.setPgmFail;
      enErrQ  <= (enErrQ  & ~errStb.clrErr) | errStb.setEnable;
      readValid <= rdStrobe && !(mode == MODE_ARRAY && opState == OP_RUN);
    end
  end

  always_comb begin
    statusByte              = '0;
    statusByte[BIT_READY]   = (opState != OP_RUN);
    statusByte[BIT_ERSSUSP] = (opState == OP_SUSP) && opErase;
    statusByte[BIT_PGMSUSP] = (opState == OP_SUSP) && !opErase;
    statusByte[BIT_ERSERR]  = ersErrQ;
    statusByte[BIT_PGMERR]  = pgmErrQ;
    statusByte[BIT_ENERR]   = enErrQ;
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CMD_W    = 8,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStrobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdStrobe,
  input  logic                progEnable,
  input  logic                opStart,
  input  logic                opIsErase,
  input  logic                opDone,
  input  logic                opFail,
  input  logic                suspendReq,
  input  logic                resumeReq,
  output logic [1:0]          readMode,
  output logic                readValid,
  output logic [STATUS_W-1:0] statusByte
);

  readMode_e  modeQ;
  opState_e   stateQ;
  logic       eraseQ;
  errStrobe_t errStb;

  flash_cmd_fsm #(.CMD_W(CMD_W)) uFsm (
    .clk        (clk),
    .rstN       (rstN),
    .wrStrobe   (wrStrobe),
    .cmdByte    (wrData[CMD_W-1:0]),
    .progEnable (progEnable),
    .opStart    (opStart),
    .opIsErase  (opIsErase),
    .opDone     (opDone),
    .opFail     (opFail),
    .suspendReq (suspendReq),
    .resumeReq  (resumeReq),
    .modeQ      (modeQ),
    .stateQ     (stateQ),
    .eraseQ     (eraseQ),
    .errStb     (errStb)
  );

  flash_cmd_status #(.STATUS_W(STATUS_W)) uStatus (
    .clk        (clk),
    .rstN       (rstN),
    .errStb     (errStb),
    .opState    (stateQ),
    .opErase    (eraseQ),
    .mode       (modeQ),
    .rdStrobe   (rdStrobe),
    .readValid  (readValid),
    .statusByte (statusByte)
  );

  assign readMode = modeQ;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrStrobe,
  input logic [15:0] wrData,
  input logic        rdStrobe,
  input logic        progEnable,
  input logic        opStart,
  input logic        opDone,
  input logic        resumeReq,
  input logic [1:0]  readMode,
  input logic        readValid,
  input logic [7:0]  statusByte
);

  logic isClear, isKnown, idleNow;
  assign isClear = wrStrobe && (wrData[7:0] == 8'h50);
  assign isKnown = (wrData[7:0] == 8'hFF) || (wrData[7:0] == 8'h70) ||
                   (wrData[7:0] == 8'h90) || (wrData[7:0] == 8'h98) ||
                   (wrData[7:0] == 8'h50);
  assign idleNow = statusByte[7] && !statusByte[6] && !statusByte[2];

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isClear && !opDone && !opStart) |=> (statusByte[5:3] == 3'b000 && readMode == 2'd1));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !isClear |=> (($past(statusByte[5:3]) & ~statusByte[5:3]) == 3'b000));

  assert_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && progEnable && idleNow) |=> (readMode == 2'd1 && !statusByte[7]));

  assert_unknown_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !isKnown) |=> (statusByte[5:4] == 2'b11));

  assert_resume_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resumeReq && (statusByte[6] || statusByte[2])) |=> (readMode == 2'd1 && !statusByte[7]));

  assert_array_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && readMode == 2'd0 && !statusByte[7]) |=> !readValid);

  assert_no_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !readValid);

endmodule

bind flash_cmd_ctrl flash_cmd_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrStrobe   (wrStrobe),
  .wrData     (wrData),
  .rdStrobe   (rdStrobe),
  .progEnable (progEnable),
  .opStart    (opStart),
  .opDone     (opDone),
  .resumeReq  (resumeReq),
  .readMode   (readMode),
  .readValid  (readValid),
  .statusByte (statusByte)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdStrobe = 1'b0;
  logic        progEnable = 1'b1;
  logic        opStart = 1'b0;
  logic        opIsErase = 1'b0;
  logic        opDone = 1'b0;
  logic        opFail = 1'b0;
  logic        suspendReq = 1'b0;
  logic        resumeReq = 1'b0;
  logic [1:0]  readMode;
  logic        readValid;
  logic [7:0]  statusByte;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .progEnable(progEnable), .opStart(opStart),
    .opIsErase(opIsErase), .opDone(opDone), .opFail(opFail),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .readMode(readMode), .readValid(readValid), .statusByte(statusByte)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge and cleared at the next one,
  // so the outputs read after this task show the result of one rising edge.
  task automatic wr(input logic [15:0] d);
    wrStrobe = 1'b1; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0; wrData = '0;
  endtask

  task automatic rd();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic start(input logic erase);
    opStart = 1'b1; opIsErase = erase;
    @(negedge clk);
    opStart = 1'b0; opIsErase = 1'b0;
  endtask

  task automatic done(input logic fail);
    opDone = 1'b1; opFail = fail;
    @(negedge clk);
    opDone = 1'b0; opFail = 1'b0;
  endtask

  task automatic suspend();
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
  endtask

  task automatic resume();
    resumeReq = 1'b1;
    @(negedge clk);
    resumeReq = 1'b0;
  endtask

  task automatic testReset();
    check("R1 mode", readMode, 0);
    check("R1 status", statusByte, 8'h80);
    check("R1 valid", readValid, 0);
  endtask

  task automatic testModes();
    wr(16'h0070); check("R2 status mode", readMode, 1);
    wr(16'h0090); check("R2 ident mode", readMode, 2);
    wr(16'h0098); check("R2 query mode", readMode, 3);
    wr(16'h00FF); check("R2 array mode", readMode, 0);
    wr(16'hAB90); check("R3 high byte ignored", readMode, 2);
    wr(16'h1270); check("R3 high byte ignored", readMode, 1);
    check("R3 no error", statusByte, 8'h80);
  endtask

  task automatic testUnknown();
    wr(16'h0090);
    wr(16'h0033);
    check("R8 mode kept", readMode, 2);
    check("R8 error bits", statusByte, 8'hB0);
    rd();
    wr(16'h0098);
    check("R5 sticky", statusByte, 8'hB0);
    progEnable = 1'b0;
    wr(16'h0050);
    check("R4 cleared", statusByte, 8'h80);
    check("R4 mode", readMode, 1);
    progEnable = 1'b1;
  endtask

  task automatic testEnable();
    wr(16'h00FF);
    progEnable = 1'b0;
    start(1'b0);
    check("R7 enable error", statusByte, 8'h88);
    check("R7 mode", readMode, 1);
    progEnable = 1'b1;
    wr(16'h0050);
    check("R4 clear enable err", statusByte, 8'h80);
  endtask

  task automatic testProgram();
    wr(16'h00FF);
    start(1'b0);
    check("R6 busy", statusByte, 8'h00);
    check("R6 mode", readMode, 1);
    rd(); check("R10 status read valid", readValid, 1);
    wr(16'h00FF); check("R2 array while busy", readMode, 0);
    rd(); check("R10 array read invalid", readValid, 0);
    done(1'b0);
    check("R12 ready", statusByte, 8'h80);
    rd(); check("R10 array read valid", readValid, 1);
    @(negedge clk); check("R10 valid drops", readValid, 0);
  endtask

  task automatic testEraseSuspend();
    start(1'b1);
    check("R6 erase busy", statusByte, 8'h00);
    suspend();
    check("R9 erase suspended", statusByte, 8'hC0);
    wr(16'h00FF); check("R9 array in suspend", readMode, 0);
    rd(); check("R10 array valid in suspend", readValid, 1);
    resume();
    check("R9 resume mode", readMode, 1);
    check("R9 resume busy", statusByte, 8'h00);
    done(1'b1);
    check("R11 erase fail", statusByte, 8'hA0);
    wr(16'h0050);
  endtask

  task automatic testProgramSuspend();
    start(1'b0);
    suspend();
    check("R9 program suspended", statusByte, 8'h84);
    resume();
    done(1'b1);
    check("R11 program fail", statusByte, 8'h90);
    wr(16'h0050);
  endtask

  task automatic testMask();
    start(1'b1);
    suspend();
    wr(16'h0020);
    check("R8 seq error in suspend", statusByte, 8'hF0);
    resume();
    check("R9 resume after error", statusByte, 8'h30);
    done(1'b1);
    check("R11 erase error masked", statusByte, 8'hB0);
    wr(16'h0050);
    check("R4 final clear", statusByte, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testUnknown();
    testEnable();
    testProgram();
    testEraseSuspend();
    testProgramSuspend();
    testMask();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule